// File: doc/BRIEF.md
# Multi-Channel Fixed-Resolution PWM Generator

This block drives a bank of pulse-width-modulated output pins from one reference clock. Each channel divides the reference clock by a programmable ratio between 17 and 32 to form a quantum. The output period is always 1024 quanta long. A 10-bit duty field sets how many quanta the output stays high at the start of each period, from 1 to 1024.

Software sets each channel through a byte-wide register port with a write strobe and a combinational read path. Each channel owns two adjacent byte registers, and one shared register holds an enable bit per channel. New duty and frequency values go into shadow registers. A running channel adopts them only when a period ends, so no period is ever cut short or stretched. A channel with its enable bit clear drives its pin low. That is the only way to get zero duty, because the duty field is stored as the high time minus one.

Top module: `pwm_bank`

## Requirements
- R1: One quantum lasts (32 − F) reference cycles, where F is the channel's 4-bit frequency code. The period is 1024 × (32 − F) cycles for every F.
- R2: For a duty field D, the output is high for the first (D + 1) × (32 − F) cycles of each period and low for the rest. With D = 1023 the output stays high without a break.
- R3: Channel i owns the byte register at BASE_ADDR + 2i and the one at BASE_ADDR + 2i + 1. The first holds D[7:0]. The second holds D[9:8] in bits [1:0] and F in bits [7:4]. Both read back the last value written to them.
- R4: Bits [3:2] of each channel's second register always read as 0, and writes to them have no effect. Any address that is not mapped reads as 0, and a write to it changes no register.
- R5: The enable register at EN_ADDR holds channel i's enable in bit i, and bits above N_CH − 1 read as 0. On the second clock edge after the write that clears a channel's bit, that channel's output goes low, and it stays low while the bit is clear.
- R6: A duty or frequency write made while a channel runs has no effect on its output until its current period has finished. The next period uses the new values in full.
- R7: When a write sets a channel's enable bit, its output goes high on the second clock edge after that write, and a fresh period starts from quantum 0.
- R8: While reset is asserted, all outputs are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | ADDR_W | Register address for both reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| pwm_out | output | N_CH | One PWM output per channel |

## Verification
The bench goes after the extremes of the duty field. With D = 0 the output must be a single quantum wide, and a design that forgot the minus-one storage would produce no pulse at all. With D = 1023 the output must never drop, and an off-by-one compare would show a one-quantum gap at the end of every period. It also rewrites a running channel halfway through a period. A design without shadowing would show a period that is truncated or stretched, and the per-cycle reference model would flag the first wrong cycle. Enable toggles check that a restart begins at quantum 0, where a counter left free-running would put the first rising edge in the wrong place. They also check that the output drops within two edges.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
    localparam int unsigned DUTY_W = 10;
    localparam int unsigned FREQ_W = 4;
    localparam int unsigned PRE_W  = 5;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [DUTY_W-1:0] duty;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned       N_CH      = 4,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 'h30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [7:0]                 reg_wdata,
    output logic [7:0]                 reg_rdata,
    output chan_cfg_t [N_CH-1:0]       shadow_cfg,
    output logic [N_CH-1:0]            chan_en
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * N_CH);

    typedef struct packed {
        chan_cfg_t [N_CH-1:0] cfg;
        logic [N_CH-1:0]      en;
    } regs_t;

    regs_t             st_d, st_q;
    logic [ADDR_W-1:0] offset;
    logic              in_bank;

    always_comb begin
        offset    = reg_addr - BASE_ADDR;
        in_bank   = (reg_addr >= BASE_ADDR) && (offset < SPAN);
        st_d      = st_q;
        reg_rdata = '0;
        if (reg_addr == EN_ADDR) begin
            reg_rdata[N_CH-1:0] = st_q.en;
            if (reg_we) st_d.en = reg_wdata[N_CH-1:0];
        end
        for (int i = 0; i < N_CH; i++) begin
            if (in_bank && offset == ADDR_W'(2 * i)) begin
                reg_rdata = st_q.cfg[i].duty[7:0];
                if (reg_we) st_d.cfg[i].duty[7:0] = reg_wdata;
            end
            if (in_bank && offset == ADDR_W'(2 * i + 1)) begin
                reg_rdata = {st_q.cfg[i].freq, 2'b00, st_q.cfg[i].duty[9:8]};
                if (reg_we) begin
                    st_d.cfg[i].duty[9:8] = reg_wdata[1:0];
                    st_d.cfg[i].freq      = reg_wdata[7:4];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_cfg = st_q.cfg;
    assign chan_en    = st_q.en;
endmodule

// File: rtl/pwm_bank_chan.sv
`timescale 1ns/1ps
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  chan_cfg_t         shadow,
    output logic              pwm_o,
    output logic [PRE_W-1:0]  pre_o,
    output logic [DUTY_W-1:0] qcnt_o,
    output chan_cfg_t         active_o
);
    localparam logic [DUTY_W-1:0] LAST_Q = '1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DUTY_W-1:0] qcnt;
        chan_cfg_t         act;
        logic              out;
    } chan_t;

    chan_t            st_d, st_q;
    logic [PRE_W-1:0] last_pre;

    always_comb begin
        st_d     = st_q;
        last_pre = 5'd31 - PRE_W'(st_q.act.freq);
        if (!en) begin
            st_d.pre  = '0;
            st_d.qcnt = '0;
            st_d.act  = shadow;
            st_d.out  = 1'b0;
        end else begin
            st_d.out = (st_q.qcnt <= st_q.act.duty);
            if (st_q.pre == last_pre) begin
                st_d.pre = '0;
                if (st_q.qcnt == LAST_Q) begin
                    st_d.qcnt = '0;
                    st_d.act  = shadow;
                end else begin
                    st_d.qcnt = st_q.qcnt + 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o    = st_q.out;
    assign pre_o    = st_q.pre;
    assign qcnt_o   = st_q.qcnt;
    assign active_o = st_q.act;
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned       N_CH      = 4,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [N_CH-1:0]   pwm_out
);
    chan_cfg_t [N_CH-1:0]              shadow_cfg;
    chan_cfg_t [N_CH-1:0]              active_cfg;
    logic      [N_CH-1:0]              chan_en;
    logic      [N_CH-1:0][PRE_W-1:0]   pre_vec;
    logic      [N_CH-1:0][DUTY_W-1:0]  qcnt_vec;

    pwm_bank_regs #(
        .N_CH(N_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .EN_ADDR(EN_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .shadow_cfg(shadow_cfg), .chan_en(chan_en)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk(clk), .rst_n(rst_n), .en(chan_en[g]), .shadow(shadow_cfg[g]),
            .pwm_o(pwm_out[g]), .pre_o(pre_vec[g]), .qcnt_o(qcnt_vec[g]),
            .active_o(active_cfg[g])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int unsigned       N_CH      = 4,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [7:0]                      reg_rdata,
    input logic [N_CH-1:0]                 pwm_out,
    input logic [N_CH-1:0]                 chan_en,
    input logic [N_CH-1:0][PRE_W-1:0]      pre_vec,
    input logic [N_CH-1:0][DUTY_W-1:0]     qcnt_vec,
    input chan_cfg_t [N_CH-1:0]            active_cfg
);
    logic [ADDR_W-1:0] offs;
    logic              upper_reg;
    assign offs      = reg_addr - BASE_ADDR;
    assign upper_reg = (reg_addr >= BASE_ADDR) && (offs < ADDR_W'(2 * N_CH)) && offs[0];

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        upper_reg |-> (reg_rdata[3:2] == 2'b00));

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(chan_en[g]) |-> !pwm_out[g]);

        a_r1_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
            pre_vec[g] <= (5'd31 - PRE_W'(active_cfg[g].freq)));

        a_r7_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[g]) |-> ($past(pre_vec[g]) == '0 && $past(qcnt_vec[g]) == '0));

        a_r2_full_high: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(chan_en[g]) && $past(active_cfg[g].duty) == 10'h3FF) |-> pwm_out[g]);

        a_r6_swap_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(active_cfg[g]) |-> (pre_vec[g] == '0 && qcnt_vec[g] == '0));
    end
endmodule

bind pwm_bank pwm_bank_chk #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .chan_en(chan_en), .pre_vec(pre_vec),
    .qcnt_vec(qcnt_vec), .active_cfg(active_cfg)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
    localparam int NCH = 4;
    localparam logic [7:0] BASE = 8'h20;
    localparam logic [7:0] ENA  = 8'h30;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    // reference model state (integers, behavioural)
    int m_d[NCH];
    int m_f[NCH];
    bit m_en[NCH];
    int t[NCH];
    int a_div[NCH];
    int a_hi[NCH];
    bit exp_o[NCH];

    pwm_bank #(.N_CH(NCH), .ADDR_W(8), .BASE_ADDR(BASE), .EN_ADDR(ENA)) u_pwm_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic chk(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // model advances on each rising edge using pre-edge register contents
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_d[c] = 0; m_f[c] = 0; m_en[c] = 0; t[c] = 0;
                a_div[c] = 32; a_hi[c] = 32; exp_o[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (!m_en[c]) begin
                    t[c] = 0;
                    a_div[c] = 32 - m_f[c];
                    a_hi[c] = (m_d[c] + 1) * a_div[c];
                    exp_o[c] = 0;
                end else begin
                    exp_o[c] = (t[c] < a_hi[c]);
                    t[c]++;
                    if (t[c] == 1024 * a_div[c]) begin
                        t[c] = 0;
                        a_div[c] = 32 - m_f[c];
                        a_hi[c] = (m_d[c] + 1) * a_div[c];
                    end
                end
            end
            if (reg_we) begin
                if (reg_addr == ENA)
                    for (int c = 0; c < NCH; c++) m_en[c] = reg_wdata[c];
                for (int c = 0; c < NCH; c++) begin
                    if (reg_addr == BASE + 8'(2 * c))
                        m_d[c] = (m_d[c] & 'h300) | int'(reg_wdata);
                    if (reg_addr == BASE + 8'(2 * c + 1)) begin
                        m_d[c] = (m_d[c] & 'hFF) | (int'(reg_wdata[1:0]) << 8);
                        m_f[c] = int'(reg_wdata[7:4]);
                    end
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge (R1, R2, R6 waveform)
    always @(negedge clk) begin
        if (rst_n && !done)
            for (int c = 0; c < NCH; c++)
                chk(pwm_out[c] == exp_o[c], "R2 waveform vs model", int'(pwm_out[c]), int'(exp_o[c]));
    end

    always @(posedge clk) begin
        if (cyc >= 190000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [7:0] expv, string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == expv, req, int'(reg_rdata), int'(expv));
    endtask

    task automatic measure(int c, int ehi, int eper, string req);
        int hi = 0;
        int per = 0;
        while (pwm_out[c] !== 1'b0) @(negedge clk);
        while (pwm_out[c] !== 1'b1) @(negedge clk);
        while (pwm_out[c] === 1'b1) begin hi++; per++; @(negedge clk); end
        while (pwm_out[c] === 1'b0) begin per++; @(negedge clk); end
        chk(hi == ehi, {req, " high time"}, hi, ehi);
        chk(per == eper, {req, " period"}, per, eper);
    endtask

    initial begin
        // R8: reset state
        #5;
        chk(pwm_out == '0, "R8 outputs in reset", int'(pwm_out), 0);
        reg_addr = BASE; #1;
        chk(reg_rdata == 8'h00, "R8 duty reg in reset", int'(reg_rdata), 0);
        reg_addr = ENA; #1;
        chk(reg_rdata == 8'h00, "R8 enable reg in reset", int'(reg_rdata), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 / R4 register layout and reserved bits
        wr(BASE + 8'd1, 8'hFF);
        rd_chk(BASE + 8'd1, 8'hF3, "R4 reserved bits read zero");
        wr(BASE + 8'd5, 8'h5A);
        rd_chk(BASE + 8'd5, 8'h52, "R3 upper reg readback");
        wr(8'h10, 8'hAA);
        rd_chk(8'h10, 8'h00, "R4 unmapped reads zero");
        wr(ENA, 8'hFF);
        rd_chk(ENA, 8'h0F, "R5 enable upper bits zero");
        wr(ENA, 8'h00);
        rd_chk(ENA, 8'h00, "R5 enable cleared");

        // programme: ch0 F=15 D=0, ch1 F=0 D=1023, ch2 F=8 D=511, ch3 F=3 D=99
        wr(BASE + 8'd0, 8'h00); wr(BASE + 8'd1, 8'hF0);
        wr(BASE + 8'd2, 8'hFF); wr(BASE + 8'd3, 8'h03);
        wr(BASE + 8'd4, 8'hFF); wr(BASE + 8'd5, 8'h81);
        wr(BASE + 8'd6, 8'd99); wr(BASE + 8'd7, 8'h30);
        rd_chk(BASE + 8'd4, 8'hFF, "R3 lower reg readback");
        rd_chk(BASE + 8'd7, 8'h30, "R3 upper reg readback F=3");

        // R7: enable timing
        wr(ENA, 8'h0F);
        chk(pwm_out[0] == 1'b0, "R7 low one edge after enable write", int'(pwm_out[0]), 0);
        @(negedge clk);
        chk(pwm_out == 4'hF, "R7 high two edges after enable write", int'(pwm_out), 15);

        // R1/R2: D=0 minimal pulse, F=15
        measure(0, 17, 17408, "R1 R2 ch0 F=15 D=0");

        // R6: mid-period rewrite of ch2 (currently F=8 D=511)
        repeat (300) @(negedge clk);
        wr(BASE + 8'd4, 8'h00);
        wr(BASE + 8'd5, 8'hF0);
        chk(pwm_out[2] == 1'b1, "R6 old duty still in force", int'(pwm_out[2]), 1);
        measure(2, 17, 17408, "R6 ch2 new settings after boundary");

        // R2: D=1023 never drops (model compares every cycle); R5 disable
        chk(pwm_out[1] == 1'b1, "R2 D=1023 high", int'(pwm_out[1]), 1);
        wr(ENA, 8'h0D);
        chk(pwm_out[1] == 1'b1, "R5 one edge after clear", int'(pwm_out[1]), 1);
        @(negedge clk);
        chk(pwm_out[1] == 1'b0, "R5 low two edges after clear", int'(pwm_out[1]), 0);
        repeat (50) @(negedge clk);
        chk(pwm_out[1] == 1'b0, "R5 stays low", int'(pwm_out[1]), 0);

        // R7: re-enable ch1 with F=15 D=3 restarts at quantum 0
        wr(BASE + 8'd2, 8'h03); wr(BASE + 8'd3, 8'hF0);
        wr(ENA, 8'h0F);
        @(negedge clk);
        chk(pwm_out[1] == 1'b1, "R7 restart high", int'(pwm_out[1]), 1);
        repeat (67) @(negedge clk);
        chk(pwm_out[1] == 1'b1, "R7 last high cycle of quantum 3", int'(pwm_out[1]), 1);
        @(negedge clk);
        chk(pwm_out[1] == 1'b0, "R7 low after 4 quanta", int'(pwm_out[1]), 0);

        measure(3, 100 * 29, 1024 * 29, "R1 R2 ch3 F=3 D=99");

        done = 1;
        summary();
        $finish;
    end
endmodule